// File: doc/BRIEF.md
# Divider Configuration Loader for a Clock Synthesizer

This block holds the configuration word that steers a frequency synthesizer's dividers: a 9-bit feedback divide value, a 2-bit post-divider code and a 3-bit test-select code. The word can be written in two ways. The first is a parallel bus qualified by an active-low parallel strobe. The second is a serial stream that has its own serial clock, its own data line and a load strobe. Both paths write the same active registers. Each path has a phase in which the registers follow the input and a phase in which they hold their value. A serial transfer replaces whatever the parallel path last captured.

All four control lines and the parallel bus are asynchronous to the block. Each one passes through a two-flop synchronizer clocked by a fast system clock. Edges are then found on the synchronized copies. The block drives the active values to the divider logic. It also decodes the post-divider code into a one-hot divide ratio and flags a feedback value that lies outside the lockable window. When the test code is zero, it exposes the oldest bit of the serial shift register on a test pin.

Top module: `divcfg_top`

## Requirements
- R1: After reset the active feedback value is 511, the post-divider code is 2'b11, the test code is 3'b000, the shift register holds all zeros, the test pin is 0, the range flag is 1 and the ratio output is 1.
- R2: While the synchronized parallel strobe is low, the active feedback value and post-divider code follow the parallel bus, and the test code is 3'b000.
- R3: After the parallel strobe rises, the active values keep the last bus value seen while the strobe was low. Later changes on the bus have no effect until the strobe falls again or a serial load takes place.
- R4: While the parallel strobe is high, each rising edge of the serial clock shifts the serial data bit into bit 0 of a 14-bit shift register, and older bits move toward bit 13. While the parallel strobe is low, the serial clock does not shift.
- R5: A rising edge of the serial load strobe, with the parallel strobe high, copies the shift register into the active values. Bits 13:11 become the test code, bits 10:9 become the post-divider code and bits 8:0 become the feedback value. For a frame sent in the order test code MSB first, then post-divider code MSB first, then feedback value MSB first, this leaves the last bit sent in feedback bit 0.
- R6: Once the serial load strobe has fallen, the active values hold while further frames are shifted in.
- R7: While the serial load strobe is held high (parallel strobe high), every serial clock rising edge writes the newly shifted register contents directly into the active values.
- R8: The ratio output decodes the active post-divider code as follows: 00 gives 2, 01 gives 4, 10 gives 8 and 11 gives 1.
- R9: The range flag is 1 exactly when the active feedback value is below 125 or above 350.
- R10: When the active test code is 3'b000, the test pin shows shift-register bit 13. Otherwise the test pin is 0.
- R11: A bus change made while the parallel strobe is low reaches the active outputs on the third rising system-clock edge after the change, and not before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to sample every control line |
| rst | input | 1 | Synchronous active-high reset |
| pload_n | input | 1 | Parallel strobe, active low |
| par_m | input | 9 | Parallel feedback divide value |
| par_n | input | 2 | Parallel post-divider code |
| sclk | input | 1 | Serial clock |
| sdata | input | 1 | Serial data |
| sload | input | 1 | Serial load strobe |
| m_act | output | 9 | Active feedback divide value |
| n_act | output | 2 | Active post-divider code |
| t_act | output | 3 | Active test-select code |
| div_ratio | output | 4 | One-hot post-divide ratio (1, 2, 4 or 8) |
| m_flag | output | 1 | Feedback value outside the lockable window |
| test_out | output | 1 | Oldest shift-register bit when the test code is zero |

## Verification
The bench covers four patterns. Parallel writes separate the follow phase from the hold phase. Full serial frames followed by a load pulse confirm the field positions and the bit order. Frames shifted without a load, or with the parallel strobe low, show that the active values and the shift register stay untouched. Shifting with the load strobe held high shows that each edge reaches the outputs directly. Directed values at 124, 125, 350 and 351, together with all four post-divider codes, pin down the range flag and the ratio decode. A single cycle-exact step on the bus fixes the synchronizer latency. Random mixes of these operations, driven from a fixed seed, then show that the two paths override each other in the stated order.

// File: rtl/divcfg_pkg.sv
package divcfg_pkg;
  parameter int unsigned M_W     = 9;
  parameter int unsigned N_W     = 2;
  parameter int unsigned T_W     = 3;
  parameter int unsigned RATIO_W = 4;
  localparam int unsigned FRAME_W = T_W + N_W + M_W;

  typedef struct packed {
    logic [T_W-1:0] t;
    logic [N_W-1:0] n;
    logic [M_W-1:0] m;
  } cfg_t;

  localparam cfg_t CFG_RST = '{t: '0, n: '1, m: '1};

  function automatic logic [RATIO_W-1:0] ratio_of(input logic [N_W-1:0] code);
    logic [RATIO_W-1:0] r;
    unique case (code)
      2'b00:   r = 4'b0010;
      2'b01:   r = 4'b0100;
      2'b10:   r = 4'b1000;
      default: r = 4'b0001;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/divcfg_sync.sv
module divcfg_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) stg[i] <= RST_VAL;
        else if (i == 0) stg[i] <= d;
        else stg[i] <= stg[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/divcfg_edge.sv
module divcfg_edge #(
  parameter int unsigned W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] lvl,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  logic [W-1:0] prev;

  always_ff @(posedge clk) begin
    if (rst) prev <= RST_VAL;
    else     prev <= lvl;
  end

  assign rise = lvl & ~prev;
  assign fall = ~lvl & prev;
endmodule

// File: rtl/divcfg_shreg.sv
module divcfg_shreg #(
  parameter int unsigned W = 14
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         shift,
  input  logic         din,
  output logic [W-1:0] q,
  output logic [W-1:0] q_nxt
);
  assign q_nxt = {q[W-2:0], din};

  always_ff @(posedge clk) begin
    if (rst)        q <= '0;
    else if (shift) q <= q_nxt;
  end
endmodule

// File: rtl/divcfg_top.sv
module divcfg_top
  import divcfg_pkg::*;
#(
  parameter int unsigned M_LO        = 125,
  parameter int unsigned M_HI        = 350,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               pload_n,
  input  logic [M_W-1:0]     par_m,
  input  logic [N_W-1:0]     par_n,
  input  logic               sclk,
  input  logic               sdata,
  input  logic               sload,
  output logic [M_W-1:0]     m_act,
  output logic [N_W-1:0]     n_act,
  output logic [T_W-1:0]     t_act,
  output logic [RATIO_W-1:0] div_ratio,
  output logic               m_flag,
  output logic               test_out
);
  localparam int unsigned CTL_W = 4;
  localparam int unsigned BUS_W = M_W + N_W;
  localparam logic RST_FLAG = (int'(CFG_RST.m) < M_LO) || (int'(CFG_RST.m) > M_HI);

  // control lines: {pload_n, sload, sclk, sdata}
  logic [CTL_W-1:0] ctl_s;
  logic [BUS_W-1:0] bus_s;
  logic pl_s, sl_s, sc_s, sd_s;
  logic [2:0] ed_rise, ed_fall;
  logic sl_rise, sc_rise, shift_en;
  logic [FRAME_W-1:0] sr_q, sr_nxt;
  cfg_t cur, nxt;

  divcfg_sync #(.W(CTL_W), .STAGES(SYNC_STAGES), .RST_VAL(4'b1000)) u_sync_ctl (
    .clk(clk), .rst(rst), .d({pload_n, sload, sclk, sdata}), .q(ctl_s));

  divcfg_sync #(.W(BUS_W), .STAGES(SYNC_STAGES), .RST_VAL({BUS_W{1'b1}})) u_sync_bus (
    .clk(clk), .rst(rst), .d({par_n, par_m}), .q(bus_s));

  assign {pl_s, sl_s, sc_s, sd_s} = ctl_s;

  divcfg_edge #(.W(3), .RST_VAL(3'b100)) u_edge (
    .clk(clk), .rst(rst), .lvl({pl_s, sl_s, sc_s}), .rise(ed_rise), .fall(ed_fall));

  assign sl_rise  = ed_rise[1];
  assign sc_rise  = ed_rise[0];
  assign shift_en = sc_rise & pl_s;

  divcfg_shreg #(.W(FRAME_W)) u_shreg (
    .clk(clk), .rst(rst), .shift(shift_en), .din(sd_s), .q(sr_q), .q_nxt(sr_nxt));

  always_comb begin
    nxt = cur;
    if (!pl_s) begin
      nxt.m = bus_s[M_W-1:0];
      nxt.n = bus_s[BUS_W-1:M_W];
      nxt.t = '0;
    end else if (sl_rise) begin
      nxt = cfg_t'(sr_q);
    end else if (sl_s && shift_en) begin
      nxt = cfg_t'(sr_nxt);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur       <= CFG_RST;
      m_flag    <= RST_FLAG;
      div_ratio <= ratio_of(CFG_RST.n);
    end else begin
      cur       <= nxt;
      m_flag    <= (int'(nxt.m) < M_LO) || (int'(nxt.m) > M_HI);
      div_ratio <= ratio_of(nxt.n);
    end
  end

  assign m_act    = cur.m;
  assign n_act    = cur.n;
  assign t_act    = cur.t;
  assign test_out = (cur.t == '0) ? sr_q[FRAME_W-1] : 1'b0;
endmodule

// File: rtl/divcfg_chk.sv
module divcfg_chk
  import divcfg_pkg::*;
#(
  parameter int unsigned M_LO = 125,
  parameter int unsigned M_HI = 350
) (
  input logic               clk,
  input logic               rst,
  input logic               pl_s,
  input logic               sl_s,
  input logic [M_W-1:0]     m_act,
  input logic [N_W-1:0]     n_act,
  input logic [T_W-1:0]     t_act,
  input logic [RATIO_W-1:0] div_ratio,
  input logic               m_flag,
  input logic               test_out
);
  a_r2_test_zero: assert property (@(posedge clk) disable iff (rst)
    !pl_s |=> (t_act == '0));

  a_r3_hold: assert property (@(posedge clk) disable iff (rst)
    (pl_s && !sl_s && !$past(sl_s)) |=> ($stable(m_act) && $stable(n_act) && $stable(t_act)));

  a_r4_no_shift: assert property (@(posedge clk) disable iff (rst)
    (!pl_s && !$past(pl_s)) |=> $stable(test_out));

  a_r8_ratio_onehot: assert property (@(posedge clk) disable iff (rst)
    $countones(div_ratio) == 1);

  a_r9_flag: assert property (@(posedge clk) disable iff (rst)
    m_flag == ((int'(m_act) < M_LO) || (int'(m_act) > M_HI)));

  a_r10_test_quiet: assert property (@(posedge clk) disable iff (rst)
    (t_act != '0) |-> !test_out);
endmodule

bind divcfg_top divcfg_chk #(.M_LO(M_LO), .M_HI(M_HI)) u_chk (
  .clk(clk), .rst(rst), .pl_s(pl_s), .sl_s(sl_s),
  .m_act(m_act), .n_act(n_act), .t_act(t_act),
  .div_ratio(div_ratio), .m_flag(m_flag), .test_out(test_out));

// File: tb/tb_divcfg_top.sv
module tb_divcfg_top;
  logic clk = 0, rst = 1;
  logic pload_n = 1, sclk = 0, sdata = 0, sload = 0;
  logic [8:0] par_m = '1;
  logic [1:0] par_n = '1;
  logic [8:0] m_act;
  logic [1:0] n_act;
  logic [2:0] t_act;
  logic [3:0] div_ratio;
  logic m_flag, test_out;

  int checks = 0, errors = 0;
  bit done = 0;

  // bench model
  logic [8:0]  e_m = 9'h1FF;
  logic [1:0]  e_n = 2'b11;
  logic [2:0]  e_t = 3'b000;
  logic [13:0] e_sr = '0;

  always #4 clk = ~clk;

  divcfg_top dut (
    .clk(clk), .rst(rst), .pload_n(pload_n), .par_m(par_m), .par_n(par_n),
    .sclk(sclk), .sdata(sdata), .sload(sload),
    .m_act(m_act), .n_act(n_act), .t_act(t_act),
    .div_ratio(div_ratio), .m_flag(m_flag), .test_out(test_out));

  function automatic int exp_ratio(input logic [1:0] c);
    case (c)
      2'b00: return 2;
      2'b01: return 4;
      2'b10: return 8;
      default: return 1;
    endcase
  endfunction

  function automatic bit exp_flag(input logic [8:0] m);
    return (m < 125) || (m > 350);
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic chk_all(input string tag);
    chk(tag, "m_act", m_act, e_m);
    chk(tag, "n_act", n_act, e_n);
    chk(tag, "t_act", t_act, e_t);
    chk(tag, "div_ratio", div_ratio, exp_ratio(e_n));
    chk(tag, "m_flag", m_flag, exp_flag(e_m));
    chk(tag, "test_out", test_out, (e_t == 0) ? e_sr[13] : 1'b0);
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  task automatic drive_bus(input logic [8:0] m, input logic [1:0] n);
    par_m = m; par_n = n;
    settle();
    if (!pload_n) begin e_m = m; e_n = n; e_t = 0; end
  endtask

  task automatic set_pl(input logic v);
    pload_n = v;
    settle();
    if (!v) begin e_m = par_m; e_n = par_n; e_t = 0; end
  endtask

  task automatic ser_bit(input logic b);
    sdata = b;
    settle();
    sclk = 1;
    settle();
    if (pload_n) begin
      e_sr = {e_sr[12:0], b};
      if (sload) {e_t, e_n, e_m} = e_sr;
    end
    sclk = 0;
    settle();
  endtask

  task automatic set_sl(input logic v);
    logic was;
    was = sload;
    sload = v;
    settle();
    if (v && !was && pload_n) {e_t, e_n, e_m} = e_sr;
  endtask

  task automatic frame(input logic [13:0] w);
    for (int i = 13; i >= 0; i--) ser_bit(w[i]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1357));
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk_all("R1");

    // R11 exact latency, R2 follow
    pload_n = 0;
    settle();
    e_t = 0;
    par_m = 9'd200; par_n = 2'b00;
    @(negedge clk); @(negedge clk);
    chk("R11", "m_act before third edge", m_act, 511);
    @(negedge clk);
    chk("R11", "m_act on third edge", m_act, 200);
    settle();
    e_m = 200; e_n = 0;
    chk_all("R2");

    // R3 hold after strobe rise
    set_pl(1);
    drive_bus(9'd100, 2'b10);
    chk_all("R3");

    // R4 shift without load; R10 test pin tracks bit 13
    frame({3'b000, 2'b01, 9'd300});
    chk_all("R4");
    chk("R4", "test_out oldest bit", test_out, 0);

    // R5 serial load transfers fields
    set_sl(1);
    chk_all("R5");
    chk("R5", "m_act field", m_act, 300);
    set_sl(0);

    // R6 held after load strobe falls
    frame({3'b101, 2'b10, 9'd130});
    chk_all("R6");
    chk("R6", "m_act held", m_act, 300);

    // R10 nonzero test code silences test pin
    set_sl(1); set_sl(0);
    chk_all("R10");

    // R4 no shift while parallel strobe low
    set_pl(0);
    frame(14'h3FFF);
    chk_all("R4");
    set_pl(1);
    chk_all("R3");

    // R7 transparent serial load
    set_sl(1);
    for (int i = 0; i < 6; i++) begin
      ser_bit(i[0]);
      chk_all("R7");
    end
    set_sl(0);

    // R8 every post-divider code, R9 window edges
    set_pl(0);
    for (int c = 0; c < 4; c++) begin
      drive_bus(9'd200, c[1:0]);
      chk_all("R8");
    end
    drive_bus(9'd124, 2'b00); chk_all("R9");
    drive_bus(9'd125, 2'b00); chk_all("R9");
    drive_bus(9'd350, 2'b00); chk_all("R9");
    drive_bus(9'd351, 2'b00); chk_all("R9");
    set_pl(1);

    // random mix
    for (int it = 0; it < 25; it++) begin
      int op;
      op = $urandom % 4;
      case (op)
        0: begin
          set_pl(0);
          drive_bus(9'($urandom), 2'($urandom));
          chk_all("R2");
          set_pl(1);
          drive_bus(9'($urandom), 2'($urandom));
          chk_all("R3");
        end
        1: begin
          frame(14'($urandom));
          set_sl(1); chk_all("R5");
          set_sl(0); chk_all("R5");
        end
        2: begin
          set_sl(1);
          for (int k = 0; k < 3; k++) ser_bit(1'($urandom));
          chk_all("R7");
          set_sl(0);
        end
        default: begin
          frame(14'($urandom));
          chk_all("R6");
        end
      endcase
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule